// File: doc/BRIEF.md
# Control Register Access Virtualizer

This block stands between a guest's control-register accesses and the real register. Each register bit is either owned by the guest or owned by the host, as given by a host-ownership mask. A bit that the host owns reads back from a host-supplied read shadow and cannot be changed by guest writes. A bit that the guest owns reads from, and writes to, the real register.

A write is checked against two fixed-bit masks before it is committed. One mask lists bits that must be 1 and the other lists bits that may be 1. A write that breaks either rule raises a fault and leaves the register as it was. A third operation clears the task-switched flag in bit 3. It has three outcomes, chosen by bit 3 of the ownership mask and bit 3 of the shadow: the flag is cleared, the operation completes with no change, or the operation asks for an exit to the host.

The caller presents one operation per strobe. Every result is registered and appears on the cycle after the strobe. Instruction decode and the exit mechanism belong to other blocks.

Top module: `ctl_reg_virtualizer`

## Requirements
- R1: A read (op code 0) returns, for each bit, the real register bit where the ownership mask bit is 0 and the read shadow bit where it is 1. The read result holds until the next read.
- R2: With an all-zero ownership mask a read returns the real register exactly. With an all-ones mask it returns the shadow exactly.
- R3: A write (op code 1) that is not faulted loads write data into the bits whose mask bit is 0 and keeps every bit whose mask bit is 1. It then signals done.
- R4: A write faults and leaves the register unchanged when the value it would produce has a 0 in any bit set in the must-be-one mask, or a 1 in any bit clear in the may-be-one mask.
- R5: Clear-TS (op code 2) with mask bit 3 = 0 clears register bit 3 and signals done. If must-be-one bit 3 is set, it faults instead and the register is unchanged.
- R6: Clear-TS with mask bit 3 = 1 and shadow bit 3 = 0 signals done and leaves the register unchanged.
- R7: Clear-TS with mask bit 3 = 1 and shadow bit 3 = 1 requests an exit and leaves the register unchanged.
- R8: Exactly one of exit, fault and done pulses on the cycle after a strobe with op code 0, 1 or 2. None of them pulses after a cycle with no strobe, or after a strobe with the reserved code 3.
- R9: After reset the register equals the RESET_VAL parameter, read data is 0, and no pulse is active.
- R10: A read, a reserved-code operation and a cycle with no strobe never change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 0 read, 1 write, 2 clear-TS, 3 reserved |
| wr_data | input | XLEN | Write operand |
| own_mask | input | XLEN | Host-ownership mask, 1 = host owns the bit |
| read_shadow | input | XLEN | Value seen by the guest for host-owned bits |
| must_one | input | XLEN | Bits that must stay 1 |
| may_one | input | XLEN | Bits allowed to be 1 |
| rd_data | output | XLEN | Result of the last read |
| ctl_reg | output | XLEN | Current real register value |
| exit_req | output | 1 | Exit request pulse |
| fault_req | output | 1 | Fault request pulse |
| done | output | 1 | Completed-without-event pulse |

## Verification
The bound checker checks these properties on every cycle:
- at most one response pulse is active;
- every valid strobe gets exactly one response, and no strobe gets none;
- host-owned bits survive writes;
- faults and exits leave the register as it was;
- reads and idle cycles do not disturb the register;
- a read result is the per-bit mix of register and shadow.

The bench's scenarios cover:
- the fixed-bit legality decision across mixed masks;
- all eight combinations of mask, shadow and must-be-one bit 3 for clear-TS;
- the reset values;
- the all-zero and all-ones mask corners.

// File: rtl/crv_pkg.sv
package crv_pkg;
    typedef enum logic [1:0] {
        OPC_READ  = 2'd0,
        OPC_WRITE = 2'd1,
        OPC_CLRTS = 2'd2,
        OPC_RSVD  = 2'd3
    } opc_e;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_DONE  = 2'd1,
        RES_FAULT = 2'd2,
        RES_EXIT  = 2'd3
    } res_e;
endpackage

// File: rtl/crv_read_mux.sv
module crv_read_mux #(
    parameter int W = 64
) (
    input  logic [W-1:0] real_val,
    input  logic [W-1:0] shadow_val,
    input  logic [W-1:0] sel_shadow,
    output logic [W-1:0] guest_view
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign guest_view[b] = sel_shadow[b] ? shadow_val[b] : real_val[b];
    end
endmodule

// File: rtl/crv_write_merge.sv
module crv_write_merge #(
    parameter int W = 64
) (
    input  logic [W-1:0] cur_val,
    input  logic [W-1:0] new_val,
    input  logic [W-1:0] keep_mask,
    input  logic [W-1:0] must_one,
    input  logic [W-1:0] may_one,
    output logic [W-1:0] merged,
    output logic         illegal
);
    logic [W-1:0] low_bad;
    logic [W-1:0] high_bad;

    always_comb begin
        merged   = (new_val & ~keep_mask) | (cur_val & keep_mask);
        low_bad  = must_one & ~merged;
        high_bad = ~may_one & merged;
        illegal  = (|low_bad) | (|high_bad);
    end
endmodule

// File: rtl/crv_clrts_decide.sv
module crv_clrts_decide
    import crv_pkg::*;
(
    input  logic host_owns,
    input  logic shadow_bit,
    input  logic pinned_one,
    output res_e result,
    output logic do_clear
);
    always_comb begin
        do_clear = 1'b0;
        if (!host_owns) begin
            if (pinned_one) begin
                result = RES_FAULT;
            end else begin
                result   = RES_DONE;
                do_clear = 1'b1;
            end
        end else if (!shadow_bit) begin
            result = RES_DONE;
        end else begin
            result = RES_EXIT;
        end
    end
endmodule

// File: rtl/ctl_reg_virtualizer.sv
module ctl_reg_virtualizer
    import crv_pkg::*;
#(
    parameter int              XLEN      = 64,
    parameter int              TS_BIT    = 3,
    parameter logic [XLEN-1:0] RESET_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [1:0]      op_code,
    input  logic [XLEN-1:0] wr_data,
    input  logic [XLEN-1:0] own_mask,
    input  logic [XLEN-1:0] read_shadow,
    input  logic [XLEN-1:0] must_one,
    input  logic [XLEN-1:0] may_one,
    output logic [XLEN-1:0] rd_data,
    output logic [XLEN-1:0] ctl_reg,
    output logic            exit_req,
    output logic            fault_req,
    output logic            done
);
    typedef struct packed {
        logic [XLEN-1:0] regv;
        logic [XLEN-1:0] rdv;
        logic            ex;
        logic            flt;
        logic            ok;
    } state_t;

    state_t st_d, st_q;

    logic [XLEN-1:0] view;
    logic [XLEN-1:0] merged;
    logic            illegal;
    res_e            ts_res;
    logic            ts_clear;

    crv_read_mux #(.W(XLEN)) u_rmux (
        .real_val   (st_q.regv),
        .shadow_val (read_shadow),
        .sel_shadow (own_mask),
        .guest_view (view)
    );

    crv_write_merge #(.W(XLEN)) u_wmerge (
        .cur_val   (st_q.regv),
        .new_val   (wr_data),
        .keep_mask (own_mask),
        .must_one  (must_one),
        .may_one   (may_one),
        .merged    (merged),
        .illegal   (illegal)
    );

    crv_clrts_decide u_ts (
        .host_owns  (own_mask[TS_BIT]),
        .shadow_bit (read_shadow[TS_BIT]),
        .pinned_one (must_one[TS_BIT]),
        .result     (ts_res),
        .do_clear   (ts_clear)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ex  = 1'b0;
        st_d.flt = 1'b0;
        st_d.ok  = 1'b0;
        if (op_valid) begin
            case (opc_e'(op_code))
                OPC_READ: begin
                    st_d.rdv = view;
                    st_d.ok  = 1'b1;
                end
                OPC_WRITE: begin
                    if (illegal) begin
                        st_d.flt = 1'b1;
                    end else begin
                        st_d.regv = merged;
                        st_d.ok   = 1'b1;
                    end
                end
                OPC_CLRTS: begin
                    st_d.ex  = (ts_res == RES_EXIT);
                    st_d.flt = (ts_res == RES_FAULT);
                    st_d.ok  = (ts_res == RES_DONE);
                    if (ts_clear) begin
                        st_d.regv[TS_BIT] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.regv <= RESET_VAL;
            st_q.rdv  <= '0;
            st_q.ex   <= 1'b0;
            st_q.flt  <= 1'b0;
            st_q.ok   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data   = st_q.rdv;
    assign ctl_reg   = st_q.regv;
    assign exit_req  = st_q.ex;
    assign fault_req = st_q.flt;
    assign done      = st_q.ok;
endmodule

// File: rtl/crv_checker.sv
module crv_checker #(
    parameter int XLEN   = 64,
    parameter int TS_BIT = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [1:0]      op_code,
    input logic [XLEN-1:0] own_mask,
    input logic [XLEN-1:0] read_shadow,
    input logic [XLEN-1:0] must_one,
    input logic [XLEN-1:0] rd_data,
    input logic [XLEN-1:0] ctl_reg,
    input logic            exit_req,
    input logic            fault_req,
    input logic            done
);
    a_r8_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exit_req, fault_req, done}));

    a_r8_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code != 2'd3) |=> ($countones({exit_req, fault_req, done}) == 1));

    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code == 2'd3) |=> !(exit_req || fault_req || done));

    a_r10_no_touch: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code == 2'd0 || op_code == 2'd3) |=> $stable(ctl_reg));

    a_r3_owned_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd1) |=> (((ctl_reg ^ $past(ctl_reg)) & $past(own_mask)) == '0));

    a_r4_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code != 2'd2) ##1 fault_req |-> $stable(ctl_reg));

    a_r7_exit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd2 && own_mask[TS_BIT] && read_shadow[TS_BIT])
        |=> (exit_req && $stable(ctl_reg)));

    a_r5_clear_ts: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd2 && !own_mask[TS_BIT] && !must_one[TS_BIT])
        |=> (done && !ctl_reg[TS_BIT]));

    a_r1_read_mix: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd0) |=>
        (((rd_data ^ $past(read_shadow)) & $past(own_mask)) == '0) &&
        (((rd_data ^ $past(ctl_reg)) & ~$past(own_mask)) == '0));
endmodule

bind ctl_reg_virtualizer crv_checker #(.XLEN(XLEN), .TS_BIT(TS_BIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .own_mask    (own_mask),
    .read_shadow (read_shadow),
    .must_one    (must_one),
    .rd_data     (rd_data),
    .ctl_reg     (ctl_reg),
    .exit_req    (exit_req),
    .fault_req   (fault_req),
    .done        (done)
);

// File: tb/tb_ctl_reg_virtualizer.sv
module tb_ctl_reg_virtualizer;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            op_valid;
    logic [1:0]      op_code;
    logic [XLEN-1:0] wr_data, own_mask, read_shadow, must_one, may_one;
    logic [XLEN-1:0] rd_data, ctl_reg;
    logic            exit_req, fault_req, done;

    int total = 0;
    int bad   = 0;
    logic [XLEN-1:0] m_reg;
    logic [63:0]     seed = 64'h9E37_79B9_7F4A_7C15;
    bit              finished = 0;

    always #4 clk = ~clk;

    ctl_reg_virtualizer dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .wr_data(wr_data), .own_mask(own_mask), .read_shadow(read_shadow),
        .must_one(must_one), .may_one(may_one), .rd_data(rd_data),
        .ctl_reg(ctl_reg), .exit_req(exit_req), .fault_req(fault_req), .done(done)
    );

    function automatic logic [63:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // drive at negedge, outputs checked one negedge later
    task automatic run_op(logic [1:0] code);
        op_valid = 1'b1;
        op_code  = code;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic permissive_write(logic [XLEN-1:0] v);
        own_mask = '0; must_one = '0; may_one = '1; wr_data = v;
        run_op(2'd1);
        m_reg = v;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] exp_view, cand;
        logic            illegal;
        rst_n = 1'b0; op_valid = 1'b0; op_code = 2'd0;
        wr_data = '0; own_mask = '0; read_shadow = '0; must_one = '0; may_one = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        check("R9 reg", ctl_reg, '0);
        check("R9 rd", rd_data, '0);
        check("R9 pulses", {exit_req, fault_req, done}, 3'b000);
        m_reg = '0;

        // R2 corner masks
        permissive_write(64'h0123_4567_89AB_CDEF);
        read_shadow = 64'hFEDC_BA98_7654_3210;
        own_mask = '0; run_op(2'd0);
        check("R2 zero mask", rd_data, m_reg);
        own_mask = '1; run_op(2'd0);
        check("R2 ones mask", rd_data, read_shadow);

        // R1 / R10 random reads
        for (int i = 0; i < 200; i++) begin
            own_mask = rnd(); read_shadow = rnd(); wr_data = rnd();
            exp_view = (m_reg & ~own_mask) | (read_shadow & own_mask);
            run_op(2'd0);
            check("R1 read mix", rd_data, exp_view);
            check("R10 read keeps reg", ctl_reg, m_reg);
            check("R8 read done", {exit_req, fault_req, done}, 3'b001);
            op_code = 2'd3; run_op(2'd3);
            check("R8 reserved quiet", {exit_req, fault_req, done}, 3'b000);
            check("R10 reserved keeps reg", ctl_reg, m_reg);
            check("R1 read holds", rd_data, exp_view);
        end

        // R3 / R4 writes
        for (int i = 0; i < 400; i++) begin
            own_mask = rnd(); wr_data = rnd();
            if (i < 100) begin
                must_one = '0; may_one = '1;
            end else begin
                must_one = rnd() & rnd() & rnd();
                may_one  = rnd() | rnd() | rnd() | must_one;
            end
            cand    = (wr_data & ~own_mask) | (m_reg & own_mask);
            illegal = ((must_one & ~cand) != '0) || ((~may_one & cand) != '0);
            run_op(2'd1);
            if (!illegal) m_reg = cand;
            check(illegal ? "R4 fault" : "R3 write", {exit_req, fault_req, done},
                  illegal ? 3'b010 : 3'b001);
            check(illegal ? "R4 reg kept" : "R3 reg merged", ctl_reg, m_reg);
        end

        // R5 / R6 / R7 clear-TS sweep
        for (int k = 0; k < 16; k++) begin
            permissive_write(rnd() | 64'h8);
            own_mask    = rnd(); read_shadow = rnd();
            must_one    = rnd() & ~64'h8; may_one = '1;
            own_mask[3]    = k[0];
            read_shadow[3] = k[1];
            must_one[3]    = k[2];
            run_op(2'd2);
            if (!k[0] && !k[2]) begin
                m_reg[3] = 1'b0;
                check("R5 clear done", {exit_req, fault_req, done}, 3'b001);
                check("R5 bit cleared", ctl_reg, m_reg);
            end else if (!k[0]) begin
                check("R5 pinned fault", {exit_req, fault_req, done}, 3'b010);
                check("R5 reg kept", ctl_reg, m_reg);
            end else if (!k[1]) begin
                check("R6 done", {exit_req, fault_req, done}, 3'b001);
                check("R6 reg kept", ctl_reg, m_reg);
            end else begin
                check("R7 exit", {exit_req, fault_req, done}, 3'b100);
                check("R7 reg kept", ctl_reg, m_reg);
            end
        end

        // R8 idle
        @(negedge clk);
        check("R8 idle quiet", {exit_req, fault_req, done}, 3'b000);
        check("R10 idle keeps reg", ctl_reg, m_reg);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule